// File: doc/BRIEF.md
# SDRAM Command Spacing Checker

A synchronous monitor that watches a decoded DRAM command stream and reports any command that arrives earlier than the device timing allows. Every cycle it samples one command (no-op, activate, read, write, precharge, read with auto-precharge or write with auto-precharge) together with a bank number. It keeps per-bank state (idle or active) and per-bank timers. Global timers cover activate-to-activate spacing across banks and write-to-read turnaround.

All limits are given as picosecond parameters and a clock period parameter. Each limit is converted to clocks at elaboration by rounding up. The completion time of a write with auto-precharge is the sum of the rounded-up write recovery count and the rounded-up precharge count. The block also flags a row that stays open longer than the maximum open-row time. A violation is reported as a registered pulse that carries a 3-bit rule code and the offending bank. The checker only observes. It never alters the stream and never models data or electrical timing.

Top module: `sdram_cmd_spacing_chk`

## Requirements
- R1: After reset every bank is idle and viol_valid_o is low. Whenever viol_valid_o is low, viol_code_o and viol_bank_o are zero.
- R2: cmd_i encodes 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 read+auto-precharge, 6 write+auto-precharge, and 7 acts as a no-op. A violation of a command sampled at a clock edge is registered at that same edge and visible for one cycle, with viol_bank_o equal to the command's bank. The codes are 0 protocol, 1 open-time minimum, 2 open-time maximum, 3 activate-to-access, 4 activate-to-activate, 5 write-to-read, 6 read-to-precharge and 7 bank busy. A no-op never causes a code other than 2.
- R3: A read or write (with or without auto-precharge) to an idle bank, or an activate to an active bank, gives code 0. A precharge to an idle bank is legal, raises nothing and leaves that bank's timers untouched.
- R4: A precharge to an active bank fewer than ceil(T_RAS_PS/TCK_PS) cycles after its activate gives code 1.
- R5: A bank that is still active ceil(T_RAS_MAX_PS/TCK_PS)+1 cycles after its activate gives code 2, once. A precharge at exactly the maximum count raises nothing. If a command violation is reported in that cycle, the overrun is held and reported later, lowest bank first.
- R6: A read or write (plain or auto-precharge) fewer than ceil(T_RCD_PS/TCK_PS) cycles after the bank's activate gives code 3.
- R7: An activate fewer than ceil(T_RRD_PS/TCK_PS) cycles after the previous activate to any bank gives code 4.
- R8: A read fewer than WR_DATA_CLK + ceil(T_WTR_PS/TCK_PS) cycles after the most recent write to any bank gives code 5.
- R9: A precharge fewer than ceil(T_RTP_PS/TCK_PS) cycles after a read to that bank gives code 6.
- R10: A precharge fewer than WR_DATA_CLK + ceil(T_WR_PS/TCK_PS) cycles after a write to that bank gives code 7.
- R11: An activate to a bank before its precharge has completed gives code 7. Completion takes ceil(T_RP_PS/TCK_PS) cycles after a precharge, ceil(T_RTP_PS/TCK_PS)+ceil(T_RP_PS/TCK_PS) cycles after a read with auto-precharge, and WR_DATA_CLK+ceil(T_WR_PS/TCK_PS)+ceil(T_RP_PS/TCK_PS) cycles after a write with auto-precharge, each term rounded up separately.
- R12: When several rules fail at once, one code is reported. For an activate the order is protocol, then busy, then activate-to-activate. For a read it is protocol, then activate-to-access, then write-to-read. For a precharge it is open-time minimum, then read-to-precharge, then write recovery.
- R13: The monitor follows the stream even when a command violates a rule: an activate opens the bank, a precharge or auto-precharge closes it, and the timers restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | BANK_W | Bank addressed by the command |
| viol_valid_o | output | 1 | Violation pulse |
| viol_code_o | output | 3 | Rule code of the violation |
| viol_bank_o | output | BANK_W | Bank of the violation |

## Verification
The bench builds the checker with 4 banks and a 2.5 ns clock period. The limits become 18 open-time, 40 maximum open-time, 6 activate-to-access, 3 activate-to-activate, 3 write-to-read, 3 read-to-precharge, 6 write recovery and 6 precharge clocks, with a 2-cycle write data tail. The write recovery and precharge times are chosen so that both divisions have fractional parts. With these values, separate rounding gives a 14-cycle auto-precharge write completion, while rounding the sum would give 13, so a gap of 13 cycles tells the two apart. The lowered maximum open-time lets two row overruns, one deferred behind a command violation, happen within a few dozen cycles.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_RDA  = 3'd5,
    CMD_WRA  = 3'd6,
    CMD_RSVD = 3'd7
  } cmd_e;

  typedef logic [2:0] vcode_t;

  localparam vcode_t VC_PROTO   = 3'd0;
  localparam vcode_t VC_RAS_MIN = 3'd1;
  localparam vcode_t VC_RAS_MAX = 3'd2;
  localparam vcode_t VC_RCD     = 3'd3;
  localparam vcode_t VC_RRD     = 3'd4;
  localparam vcode_t VC_WTR     = 3'd5;
  localparam vcode_t VC_RTP     = 3'd6;
  localparam vcode_t VC_BUSY    = 3'd7;

  // round a picosecond limit up to whole clocks
  function automatic int unsigned ps_to_clk(input int unsigned ps, input int unsigned tck);
    return (ps + tck - 1) / tck;
  endfunction

endpackage

// File: rtl/sdram_global_timers.sv
module sdram_global_timers
  import sdram_chk_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned RRD_CLK     = 3,
  parameter int unsigned WTR_TOT_CLK = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  output logic rrd_ok_o,
  output logic wtr_ok_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] L_RRD   = CNT_W'(RRD_CLK);
  localparam logic [CNT_W-1:0] L_WTR   = CNT_W'(WTR_TOT_CLK);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] act_age_q, wr_age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_age_q <= CNT_SAT;
      wr_age_q  <= CNT_SAT;
    end else begin
      if (cmd_i == CMD_ACT)           act_age_q <= ONE;
      else if (act_age_q != CNT_SAT)  act_age_q <= act_age_q + ONE;
      if (cmd_i == CMD_WR || cmd_i == CMD_WRA) wr_age_q <= ONE;
      else if (wr_age_q != CNT_SAT)            wr_age_q <= wr_age_q + ONE;
    end
  end

  assign rrd_ok_o = (act_age_q >= L_RRD);
  assign wtr_ok_o = (wr_age_q >= L_WTR);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_chk_pkg::*;
#(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned RAS_CLK      = 18,
  parameter int unsigned RAS_MAX_CLK  = 40,
  parameter int unsigned RCD_CLK      = 6,
  parameter int unsigned RTP_CLK      = 3,
  parameter int unsigned WREC_CLK     = 8,
  parameter int unsigned RP_CLK       = 6,
  parameter int unsigned RDA_BUSY_CLK = 9,
  parameter int unsigned WRA_BUSY_CLK = 14
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   hit_i,
  input  cmd_e   cmd_i,
  input  logic   rrd_ok_i,
  input  logic   wtr_ok_i,
  input  logic   ovr_ack_i,
  output logic   viol_o,
  output vcode_t code_o,
  output logic   ovr_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] L_RAS   = CNT_W'(RAS_CLK);
  localparam logic [CNT_W-1:0] L_OVR   = CNT_W'(RAS_MAX_CLK + 1);
  localparam logic [CNT_W-1:0] L_RCD   = CNT_W'(RCD_CLK);
  localparam logic [CNT_W-1:0] L_RTP   = CNT_W'(RTP_CLK);
  localparam logic [CNT_W-1:0] L_WREC  = CNT_W'(WREC_CLK);
  localparam logic [CNT_W-1:0] B_PRE   = CNT_W'(RP_CLK - 1);
  localparam logic [CNT_W-1:0] B_RDA   = CNT_W'(RDA_BUSY_CLK - 1);
  localparam logic [CNT_W-1:0] B_WRA   = CNT_W'(WRA_BUSY_CLK - 1);

  logic             active_q;
  logic [CNT_W-1:0] act_age_q, rd_age_q, wr_age_q, busy_q;
  logic             ovr_pend_q;
  logic             ovr_now;

  function automatic logic [CNT_W-1:0] age_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_SAT) ? v : v + ONE;
  endfunction

  // rule check, priority per command
  always_comb begin
    viol_o = 1'b0;
    code_o = VC_PROTO;
    if (hit_i) begin
      unique case (cmd_i)
        CMD_ACT: begin
          if (active_q)            begin viol_o = 1'b1; code_o = VC_PROTO; end
          else if (busy_q != '0)   begin viol_o = 1'b1; code_o = VC_BUSY;  end
          else if (!rrd_ok_i)      begin viol_o = 1'b1; code_o = VC_RRD;   end
        end
        CMD_RD, CMD_RDA: begin
          if (!active_q)             begin viol_o = 1'b1; code_o = VC_PROTO; end
          else if (act_age_q < L_RCD) begin viol_o = 1'b1; code_o = VC_RCD;  end
          else if (!wtr_ok_i)        begin viol_o = 1'b1; code_o = VC_WTR;   end
        end
        CMD_WR, CMD_WRA: begin
          if (!active_q)             begin viol_o = 1'b1; code_o = VC_PROTO; end
          else if (act_age_q < L_RCD) begin viol_o = 1'b1; code_o = VC_RCD;  end
        end
        CMD_PRE: begin
          if (active_q) begin
            if (act_age_q < L_RAS)       begin viol_o = 1'b1; code_o = VC_RAS_MIN; end
            else if (rd_age_q < L_RTP)   begin viol_o = 1'b1; code_o = VC_RTP;     end
            else if (wr_age_q < L_WREC)  begin viol_o = 1'b1; code_o = VC_BUSY;    end
          end
        end
        default: ;
      endcase
    end
  end

  assign ovr_now = active_q && (act_age_q == L_OVR);
  assign ovr_o   = ovr_pend_q | ovr_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      act_age_q  <= CNT_SAT;
      rd_age_q   <= CNT_SAT;
      wr_age_q   <= CNT_SAT;
      busy_q     <= '0;
      ovr_pend_q <= 1'b0;
    end else begin
      act_age_q  <= age_inc(act_age_q);
      rd_age_q   <= age_inc(rd_age_q);
      wr_age_q   <= age_inc(wr_age_q);
      busy_q     <= (busy_q == '0) ? busy_q : busy_q - ONE;
      ovr_pend_q <= (ovr_pend_q | ovr_now) & ~ovr_ack_i;
      if (hit_i) begin
        unique case (cmd_i)
          CMD_ACT: begin
            active_q  <= 1'b1;
            act_age_q <= ONE;
          end
          CMD_RD: rd_age_q <= ONE;
          CMD_WR: wr_age_q <= ONE;
          CMD_RDA: begin
            rd_age_q <= ONE;
            active_q <= 1'b0;
            busy_q   <= B_RDA;
          end
          CMD_WRA: begin
            wr_age_q <= ONE;
            active_q <= 1'b0;
            busy_q   <= B_WRA;
          end
          CMD_PRE: begin
            if (active_q) begin
              active_q <= 1'b0;
              busy_q   <= B_PRE;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdram_viol_arbiter.sv
module sdram_viol_arbiter
  import sdram_chk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] cmd_viol_i,
  input  vcode_t               cmd_code_i [NUM_BANKS],
  input  logic [NUM_BANKS-1:0] ovr_i,
  output logic [NUM_BANKS-1:0] ovr_ack_o,
  output logic                 valid_o,
  output vcode_t               code_o,
  output logic [BANK_W-1:0]    bank_o
);

  logic              any_cmd, any_ovr;
  logic [BANK_W-1:0] cmd_sel, ovr_sel;
  vcode_t            cmd_code;

  always_comb begin
    any_cmd  = |cmd_viol_i;
    any_ovr  = |ovr_i;
    cmd_sel  = '0;
    ovr_sel  = '0;
    cmd_code = VC_PROTO;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (cmd_viol_i[b]) begin
        cmd_sel  = BANK_W'(b);
        cmd_code = cmd_code_i[b];
      end
      if (ovr_i[b]) ovr_sel = BANK_W'(b);
    end
    ovr_ack_o = '0;
    if (!any_cmd && any_ovr) ovr_ack_o[ovr_sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
      bank_o  <= '0;
    end else if (any_cmd) begin
      valid_o <= 1'b1;
      code_o  <= cmd_code;
      bank_o  <= cmd_sel;
    end else if (any_ovr) begin
      valid_o <= 1'b1;
      code_o  <= VC_RAS_MAX;
      bank_o  <= ovr_sel;
    end else begin
      valid_o <= 1'b0;
      code_o  <= '0;
      bank_o  <= '0;
    end
  end

endmodule

// File: rtl/sdram_cmd_spacing_chk.sv
module sdram_cmd_spacing_chk
  import sdram_chk_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 8,
  parameter int unsigned TCK_PS       = 2500,
  parameter int unsigned T_RAS_PS     = 45000,
  parameter int unsigned T_RAS_MAX_PS = 70000000,
  parameter int unsigned T_RCD_PS     = 15000,
  parameter int unsigned T_RRD_PS     = 7500,
  parameter int unsigned T_WTR_PS     = 7500,
  parameter int unsigned T_RTP_PS     = 7500,
  parameter int unsigned T_WR_PS      = 15000,
  parameter int unsigned T_RP_PS      = 15000,
  parameter int unsigned WR_DATA_CLK  = 4,
  localparam int unsigned BANK_W      = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              viol_valid_o,
  output logic [2:0]        viol_code_o,
  output logic [BANK_W-1:0] viol_bank_o
);

  localparam int unsigned RAS_CLK      = ps_to_clk(T_RAS_PS, TCK_PS);
  localparam int unsigned RAS_MAX_CLK  = ps_to_clk(T_RAS_MAX_PS, TCK_PS);
  localparam int unsigned RCD_CLK      = ps_to_clk(T_RCD_PS, TCK_PS);
  localparam int unsigned RRD_CLK      = ps_to_clk(T_RRD_PS, TCK_PS);
  localparam int unsigned WTR_CLK      = ps_to_clk(T_WTR_PS, TCK_PS);
  localparam int unsigned RTP_CLK      = ps_to_clk(T_RTP_PS, TCK_PS);
  localparam int unsigned WR_CLK       = ps_to_clk(T_WR_PS, TCK_PS);
  localparam int unsigned RP_CLK       = ps_to_clk(T_RP_PS, TCK_PS);
  // each term rounded on its own before the sum
  localparam int unsigned DAL_CLK      = WR_CLK + RP_CLK;
  localparam int unsigned WREC_CLK     = WR_DATA_CLK + WR_CLK;
  localparam int unsigned WTR_TOT_CLK  = WR_DATA_CLK + WTR_CLK;
  localparam int unsigned RDA_BUSY_CLK = RTP_CLK + RP_CLK;
  localparam int unsigned WRA_BUSY_CLK = WR_DATA_CLK + DAL_CLK;
  localparam int unsigned CNT_W        = $clog2(RAS_MAX_CLK + WRA_BUSY_CLK + RDA_BUSY_CLK
                                                + WREC_CLK + WTR_TOT_CLK + RCD_CLK + RRD_CLK + 4);

  cmd_e                 cmd;
  logic                 rrd_ok, wtr_ok;
  logic [NUM_BANKS-1:0] hit, cmd_viol, ovr, ovr_ack;
  vcode_t               cmd_code [NUM_BANKS];

  assign cmd = cmd_e'(cmd_i);

  sdram_global_timers #(
    .CNT_W      (CNT_W),
    .RRD_CLK    (RRD_CLK),
    .WTR_TOT_CLK(WTR_TOT_CLK)
  ) u_glob (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .rrd_ok_o(rrd_ok),
    .wtr_ok_o(wtr_ok)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign hit[g] = (bank_i == BANK_W'(g));

    sdram_bank_tracker #(
      .CNT_W       (CNT_W),
      .RAS_CLK     (RAS_CLK),
      .RAS_MAX_CLK (RAS_MAX_CLK),
      .RCD_CLK     (RCD_CLK),
      .RTP_CLK     (RTP_CLK),
      .WREC_CLK    (WREC_CLK),
      .RP_CLK      (RP_CLK),
      .RDA_BUSY_CLK(RDA_BUSY_CLK),
      .WRA_BUSY_CLK(WRA_BUSY_CLK)
    ) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit[g]),
      .cmd_i    (cmd),
      .rrd_ok_i (rrd_ok),
      .wtr_ok_i (wtr_ok),
      .ovr_ack_i(ovr_ack[g]),
      .viol_o   (cmd_viol[g]),
      .code_o   (cmd_code[g]),
      .ovr_o    (ovr[g])
    );
  end

  sdram_viol_arbiter #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_viol_i(cmd_viol),
    .cmd_code_i(cmd_code),
    .ovr_i     (ovr),
    .ovr_ack_o (ovr_ack),
    .valid_o   (viol_valid_o),
    .code_o    (viol_code_o),
    .bank_o    (viol_bank_o)
  );

endmodule

// File: rtl/sdram_cmd_spacing_chk_sva.sv
module sdram_cmd_spacing_chk_sva
  import sdram_chk_pkg::*;
#(
  parameter int unsigned BANK_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic              viol_valid_o,
  input logic [2:0]        viol_code_o,
  input logic [BANK_W-1:0] viol_bank_o
);

  assert_quiet_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol_valid_o |-> (viol_code_o == '0 && viol_bank_o == '0));

  assert_cmd_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_i) == 3'(CMD_NOP) |-> (!viol_valid_o || viol_code_o == VC_RAS_MAX));

  assert_src_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && viol_code_o != VC_RAS_MAX) |-> viol_bank_o == $past(bank_i));

  assert_rrd_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && viol_code_o == VC_RRD) |-> $past(cmd_i) == 3'(CMD_ACT));

  assert_wtr_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && viol_code_o == VC_WTR)
      |-> ($past(cmd_i) == 3'(CMD_RD) || $past(cmd_i) == 3'(CMD_RDA)));

  assert_ras_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && viol_code_o == VC_RAS_MIN) |-> $past(cmd_i) == 3'(CMD_PRE));

  assert_rtp_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && viol_code_o == VC_RTP) |-> $past(cmd_i) == 3'(CMD_PRE));

  assert_rcd_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && viol_code_o == VC_RCD)
      |-> ($past(cmd_i) inside {3'(CMD_RD), 3'(CMD_WR), 3'(CMD_RDA), 3'(CMD_WRA)}));

endmodule

bind sdram_cmd_spacing_chk sdram_cmd_spacing_chk_sva #(.BANK_W(BANK_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_i),
  .bank_i      (bank_i),
  .viol_valid_o(viol_valid_o),
  .viol_code_o (viol_code_o),
  .viol_bank_o (viol_bank_o)
);

// File: tb/tb_sdram_cmd_spacing_chk.sv
module tb_sdram_cmd_spacing_chk;

  localparam int unsigned BW = 2;
  localparam int B = 10;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, RDA = 3'd5, WRA = 3'd6;
  localparam logic [2:0] C_PROTO = 3'd0, C_RASMIN = 3'd1, C_RASMAX = 3'd2, C_RCD = 3'd3,
                         C_RRD = 3'd4, C_WTR = 3'd5, C_RTP = 3'd6, C_BUSY = 3'd7;

  typedef struct {
    logic          v;
    logic [2:0]    code;
    logic [BW-1:0] bank;
    string         req;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    cmd_i = NOP;
  logic [BW-1:0] bank_i = '0;
  logic          viol_valid_o;
  logic [2:0]    viol_code_o;
  logic [BW-1:0] viol_bank_o;

  int   n_run = 0, n_fail = 0, now = 0, cyc = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  sdram_cmd_spacing_chk #(
    .NUM_BANKS(4), .TCK_PS(2500), .T_RAS_PS(45000), .T_RAS_MAX_PS(100000),
    .T_RCD_PS(15000), .T_RRD_PS(7500), .T_WTR_PS(7500), .T_RTP_PS(7500),
    .T_WR_PS(14000), .T_RP_PS(13000), .WR_DATA_CLK(2)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .bank_i(bank_i),
    .viol_valid_o(viol_valid_o), .viol_code_o(viol_code_o), .viol_bank_o(viol_bank_o)
  );

  task automatic compare(input exp_t e);
    logic bad;
    n_run++;
    bad = (viol_valid_o !== e.v) ||
          (e.v && (viol_code_o !== e.code || viol_bank_o !== e.bank)) ||
          (!e.v && (viol_code_o !== 3'd0 || viol_bank_o !== '0));
    if (bad) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got v=%0b code=%0d bank=%0d, exp v=%0b code=%0d bank=%0d",
               e.req, now, viol_valid_o, viol_code_o, viol_bank_o, e.v, e.code, e.bank);
    end
  endtask

  // monitor: pop one expectation per edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  task automatic step(input logic [2:0] c, input logic [BW-1:0] b, input logic ev,
                      input logic [2:0] ec, input logic [BW-1:0] eb, input string req);
    exp_t e;
    @(negedge clk_i);
    cmd_i  = c;
    bank_i = b;
    e.v = ev; e.code = ev ? ec : 3'd0; e.bank = ev ? eb : '0; e.req = req;
    q.push_back(e);
    now++;
  endtask

  task automatic at(input int t, input logic [2:0] c, input logic [BW-1:0] b, input logic ev,
                    input logic [2:0] ec, input string req);
    while (now < t) step(NOP, '0, 1'b0, 3'd0, '0, "R1 quiet");
    step(c, b, ev, ec, b, req);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 5000 && !done) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1'b1;
    @(negedge clk_i);
    r.v = 1'b0; r.code = 3'd0; r.bank = '0; r.req = "R1 reset";
    compare(r);

    at(0, RD, 2'd0, 1, C_PROTO, "R3 read idle");
    at(1, WR, 2'd1, 1, C_PROTO, "R3 write idle");
    at(2, PRE, 2'd2, 0, 0, "R3 precharge idle ignored");

    at(B+0,  ACT, 2'd0, 0, 0,        "R7 first act");
    at(B+1,  ACT, 2'd1, 1, C_RRD,    "R7 act-act gap 1");
    at(B+4,  ACT, 2'd2, 0, 0,        "R7 act-act gap 3");
    at(B+5,  ACT, 2'd2, 1, C_PROTO,  "R12 act active before rrd");
    at(B+6,  WR,  2'd1, 1, C_RCD,    "R6 write gap 5");
    at(B+7,  RD,  2'd0, 1, C_WTR,    "R8 read 1 after write");
    at(B+10, RD,  2'd0, 1, C_WTR,    "R8 read 4 after write");
    at(B+11, RD,  2'd0, 0, 0,        "R8 read 5 after write");
    at(B+12, PRE, 2'd0, 1, C_RASMIN, "R4 R12 pre gap 12");
    at(B+13, ACT, 2'd0, 1, C_BUSY,   "R11 R13 act 1 after pre");
    at(B+30, RD,  2'd0, 0, 0,        "R6 read gap 17");
    at(B+31, PRE, 2'd0, 1, C_RTP,    "R9 pre 1 after read");
    at(B+32, ACT, 2'd3, 0, 0,        "R7 act bank3");
    at(B+37, ACT, 2'd0, 0, 0,        "R11 act 6 after pre");
    at(B+38, WR,  2'd3, 0, 0,        "R6 write gap 6");
    at(B+40, RD,  2'd0, 1, C_RCD,    "R12 read rcd before wtr");
    at(B+42, RD,  2'd2, 1, C_WTR,    "R8 read while overrun pending");
    at(B+43, NOP, 2'd0, 0, 0,        "dummy");
    // previous line advanced one cycle; the overrun expectation is placed here
    q[q.size()-1].v = 1'b1; q[q.size()-1].code = C_RASMAX; q[q.size()-1].bank = 2'd1;
    q[q.size()-1].req = "R5 deferred overrun bank1";
    at(B+45, WR,  2'd3, 0, 0,        "R6 write bank3");
    at(B+46, NOP, 2'd0, 0, 0,        "dummy");
    q[q.size()-1].v = 1'b1; q[q.size()-1].code = C_RASMAX; q[q.size()-1].bank = 2'd2;
    q[q.size()-1].req = "R5 overrun bank2";
    at(B+47, PRE, 2'd2, 0, 0,        "R5 pre after overrun");
    at(B+48, PRE, 2'd1, 0, 0,        "R10 pre long after write");
    at(B+50, PRE, 2'd3, 1, C_BUSY,   "R10 pre 5 after write");
    at(B+77, PRE, 2'd0, 0, 0,        "R5 pre at max open");
    at(B+78, NOP, 2'd0, 0, 0,        "R5 no overrun after close");
    at(B+80, ACT, 2'd1, 0, 0,        "R11 act bank1");
    at(B+86, WRA, 2'd1, 0, 0,        "R6 write ap");
    at(B+99, ACT, 2'd1, 1, C_BUSY,   "R11 act 13 after write ap");
    at(B+117, PRE, 2'd1, 0, 0,       "R13 pre after busy act");
    at(B+123, ACT, 2'd1, 0, 0,       "R11 act 6 after pre");
    at(B+129, WRA, 2'd1, 0, 0,       "R6 write ap again");
    at(B+143, ACT, 2'd1, 0, 0,       "R11 act 14 after write ap");
    at(B+149, RDA, 2'd1, 0, 0,       "R6 read ap");
    at(B+157, ACT, 2'd1, 1, C_BUSY,  "R11 act 8 after read ap");
    at(B+175, PRE, 2'd1, 0, 0,       "R4 pre gap 18");
    at(B+178, NOP, 2'd0, 0, 0,       "R1 quiet end");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule